// File: doc/BRIEF.md
# Flash Status Register and Write Guard

This block keeps the eight-bit status register of a serial flash memory and rules on every state-changing request that the command decoder hands it. The decoder delivers one-cycle event pulses: write-enable, write-disable, write-status with its data byte, page program, sector erase, 32 KB and 64 KB block erase, and chip erase, each with an address where one applies. The block answers each write-type request one cycle later with either a grant or a deny pulse. A grant starts a self-timed cycle that the array controller ends with a done pulse.

Protection comes from three sources. The first is a write-enable latch that the block clears by itself at the end of every cycle. The second is a hardware lock, formed by a status-protect bit together with an active-low write-protect pin. The third is a three-bit protect code that guards a region at the bottom of a 64 KB array. The status byte can be read at all times, including while a cycle runs.

Top module: `flash_status_guard`

## Requirements
- R1: After reset the status byte is 00h, and grant and deny are both 0.
- R2: When no cycle is running, a write-enable pulse sets status bit 1 (enable latch) on the next cycle. A write-disable pulse clears it.
- R3: A write-status, program or erase request made while bit 1 is 0 is denied and leaves the status byte unchanged.
- R4: An accepted write-status holds status bit 0 (busy) at 1 for exactly WRSR_CYCLES cycles. When busy falls, bit 7 and bits 4..2 take data bits 7 and 4..2, and bit 1 reads 0. Bits 6 and 5 always read 0, and data bits 6, 5, 1 and 0 have no effect.
- R5: When bit 7 is 1 and wp_n is 0, a write-status is denied and the status byte is unchanged.
- R6: The protect code in status bits 4..2 sets the protected range, which always starts at address 0. The ranges are: 000 none; 001 up to DFFFh; 010 up to BFFFh; 011 up to 7FFFh; 1xx the whole 64 KB.
- R7: A request is denied if its target overlaps the protected range. A program targets its own byte address. A sector erase targets the aligned 4 KB region around its address, and block erases target the aligned 32 KB or 64 KB region.
- R8: A chip erase is granted only when status bits 4..2 are 000.
- R9: A granted program or erase sets busy on the same cycle as the grant pulse. A cycle_done pulse clears busy and the enable latch on the next cycle.
- R10: While busy is 1, write-enable and write-disable are ignored, and every write-status, program or erase request is denied.
- R11: A denied request leaves the enable latch as it was.
- R12: Every write-status, program or erase request gets exactly one of grant or deny, one cycle after its pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_wren | input | 1 | Write-enable event pulse |
| ev_wrdi | input | 1 | Write-disable event pulse |
| ev_wrsr | input | 1 | Write-status event pulse |
| wrsr_data | input | 8 | Data byte for write-status |
| ev_prog | input | 1 | Page program request |
| ev_sect_erase | input | 1 | 4 KB sector erase request |
| ev_blk32_erase | input | 1 | 32 KB block erase request |
| ev_blk64_erase | input | 1 | 64 KB block erase request |
| ev_chip_erase | input | 1 | Whole-array erase request |
| req_addr | input | ADDR_W | Target address of a program or erase |
| wp_n | input | 1 | Write-protect pin, active low |
| cycle_done | input | 1 | End of a program or erase cycle |
| status | output | 8 | Status byte: 7 lock, 6..5 zero, 4..2 protect code, 1 enable latch, 0 busy |
| grant | output | 1 | Request accepted, cycle started |
| deny | output | 1 | Request refused |

## Verification
Every result of this block is registered once. Grant, deny, the enable latch and the rise of busy therefore show up one clock after the event pulse. The end of a program or erase shows up one clock after cycle_done. A write-status result appears on the cycle on which busy falls, WRSR_CYCLES clocks after the accepting edge. The bench drives inputs just after a rising edge and compares the behavioural model with the ports at the falling edge that follows. Each directed check therefore reads the port values produced by the edge that consumed the stimulus.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
   typedef enum logic [2:0] {
      RK_NONE  = 3'd0,
      RK_PROG  = 3'd1,
      RK_SECT  = 3'd2,
      RK_BLK32 = 3'd3,
      RK_BLK64 = 3'd4,
      RK_CHIP  = 3'd5
   } req_kind_t;

   localparam int unsigned ST_BUSY = 0;
   localparam int unsigned ST_WEL  = 1;
   localparam int unsigned ST_BP_LO = 2;
   localparam int unsigned ST_BP_HI = 4;
   localparam int unsigned ST_LOCK = 7;
endpackage

// File: rtl/fsg_protect_map.sv
module fsg_protect_map #(
   parameter int unsigned ARRAY_AW = 16
) (
   input  logic [2:0]          bp,
   output logic [ARRAY_AW:0]   limit
);
   localparam longint unsigned FULL_B = 64'd1 << ARRAY_AW;
   localparam longint unsigned SIXT_B = FULL_B >> 4;
   localparam logic [ARRAY_AW:0] LIM_FULL = (ARRAY_AW+1)'(FULL_B);
   localparam logic [ARRAY_AW:0] LIM_14   = (ARRAY_AW+1)'(SIXT_B * 14);
   localparam logic [ARRAY_AW:0] LIM_12   = (ARRAY_AW+1)'(SIXT_B * 12);
   localparam logic [ARRAY_AW:0] LIM_8    = (ARRAY_AW+1)'(SIXT_B * 8);

   if (ARRAY_AW < 4 || ARRAY_AW > 30) begin : g_bad_aw
      $error("fsg_protect_map: ARRAY_AW out of range");
   end

   always_comb begin
      unique casez (bp)
         3'b000:  limit = '0;
         3'b001:  limit = LIM_14;
         3'b010:  limit = LIM_12;
         3'b011:  limit = LIM_8;
         default: limit = LIM_FULL;
      endcase
   end
endmodule

// File: rtl/fsg_region_check.sv
module fsg_region_check
   import fsg_pkg::*;
#(
   parameter int unsigned ADDR_W    = 24,
   parameter int unsigned ARRAY_AW  = 16,
   parameter int unsigned SECT_AW   = 12,
   parameter int unsigned BLK32_AW  = 15,
   parameter int unsigned BLK64_AW  = 16
) (
   input  req_kind_t           kind,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [2:0]          bp,
   input  logic [ARRAY_AW:0]   limit,
   output logic                blocked
);
   function automatic logic [ARRAY_AW-1:0] low_mask(input int unsigned aw);
      if (aw >= ARRAY_AW) return '1;
      return ARRAY_AW'((64'd1 << aw) - 64'd1);
   endfunction

   localparam logic [ARRAY_AW-1:0] M_SECT  = low_mask(SECT_AW);
   localparam logic [ARRAY_AW-1:0] M_BLK32 = low_mask(BLK32_AW);
   localparam logic [ARRAY_AW-1:0] M_BLK64 = low_mask(BLK64_AW);

   if (!(SECT_AW <= BLK32_AW && BLK32_AW <= BLK64_AW)) begin : g_bad_order
      $error("fsg_region_check: region sizes must grow");
   end

   logic [ARRAY_AW-1:0] a_loc;
   if (ADDR_W >= ARRAY_AW) begin : g_trunc
      assign a_loc = addr[ARRAY_AW-1:0];
   end else begin : g_extend
      assign a_loc = {{(ARRAY_AW-ADDR_W){1'b0}}, addr};
   end

   logic [ARRAY_AW-1:0] base;
   always_comb begin
      unique case (kind)
         RK_SECT:  base = a_loc & ~M_SECT;
         RK_BLK32: base = a_loc & ~M_BLK32;
         RK_BLK64: base = a_loc & ~M_BLK64;
         default:  base = a_loc;
      endcase
   end

   always_comb begin
      if (kind == RK_CHIP) blocked = (bp != 3'b000);
      else                 blocked = ({1'b0, base} < limit);
   end
endmodule

// File: rtl/fsg_wrsr_timer.sv
module fsg_wrsr_timer #(
   parameter int unsigned CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic done
);
   localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

   if (CYCLES < 1) begin : g_bad_cyc
      $error("fsg_wrsr_timer: CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt;
   logic          active;

   assign done = active && (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         active <= 1'b0;
      end else if (start) begin
         cnt    <= CW'(CYCLES - 1);
         active <= 1'b1;
      end else if (active) begin
         if (cnt == '0) active <= 1'b0;
         else           cnt    <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/flash_status_guard.sv
module flash_status_guard
   import fsg_pkg::*;
#(
   parameter int unsigned ADDR_W      = 24,
   parameter int unsigned ARRAY_AW    = 16,
   parameter int unsigned WRSR_CYCLES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_wren,
   input  logic              ev_wrdi,
   input  logic              ev_wrsr,
   input  logic [7:0]        wrsr_data,
   input  logic              ev_prog,
   input  logic              ev_sect_erase,
   input  logic              ev_blk32_erase,
   input  logic              ev_blk64_erase,
   input  logic              ev_chip_erase,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              wp_n,
   input  logic              cycle_done,
   output logic [7:0]        status,
   output logic              grant,
   output logic              deny
);
   logic       lock_q, wel_q, busy_q, wrsr_run_q;
   logic [2:0] bp_q;
   logic [7:0] pend_q;

   req_kind_t  kind;
   logic       req_any, blocked, hw_locked, wrsr_ok, req_ok, tmr_done;
   logic [ARRAY_AW:0] limit;

   always_comb begin
      if      (ev_prog)        kind = RK_PROG;
      else if (ev_sect_erase)  kind = RK_SECT;
      else if (ev_blk32_erase) kind = RK_BLK32;
      else if (ev_blk64_erase) kind = RK_BLK64;
      else if (ev_chip_erase)  kind = RK_CHIP;
      else                     kind = RK_NONE;
   end

   assign req_any   = (kind != RK_NONE);
   assign hw_locked = lock_q && !wp_n;
   assign wrsr_ok   = wel_q && !hw_locked;
   assign req_ok    = wel_q && !blocked;

   fsg_protect_map #(.ARRAY_AW(ARRAY_AW)) i_map (
      .bp    (bp_q),
      .limit (limit)
   );

   fsg_region_check #(.ADDR_W(ADDR_W), .ARRAY_AW(ARRAY_AW)) i_region (
      .kind    (kind),
      .addr    (req_addr),
      .bp      (bp_q),
      .limit   (limit),
      .blocked (blocked)
   );

   fsg_wrsr_timer #(.CYCLES(WRSR_CYCLES)) i_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (!busy_q && ev_wrsr && wrsr_ok),
      .done  (tmr_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lock_q     <= 1'b0;
         bp_q       <= 3'b000;
         wel_q      <= 1'b0;
         busy_q     <= 1'b0;
         wrsr_run_q <= 1'b0;
         pend_q     <= 8'h00;
         grant      <= 1'b0;
         deny       <= 1'b0;
      end else begin
         grant <= 1'b0;
         deny  <= 1'b0;
         if (busy_q) begin
            if (ev_wrsr || req_any) deny <= 1'b1;
            if (wrsr_run_q && tmr_done) begin
               lock_q     <= pend_q[ST_LOCK];
               bp_q       <= pend_q[ST_BP_HI:ST_BP_LO];
               wel_q      <= 1'b0;
               busy_q     <= 1'b0;
               wrsr_run_q <= 1'b0;
            end else if (!wrsr_run_q && cycle_done) begin
               wel_q  <= 1'b0;
               busy_q <= 1'b0;
            end
         end else if (ev_wren) begin
            wel_q <= 1'b1;
         end else if (ev_wrdi) begin
            wel_q <= 1'b0;
         end else if (ev_wrsr) begin
            if (wrsr_ok) begin
               grant      <= 1'b1;
               busy_q     <= 1'b1;
               wrsr_run_q <= 1'b1;
               pend_q     <= wrsr_data;
            end else begin
               deny <= 1'b1;
            end
         end else if (req_any) begin
            if (req_ok) begin
               grant  <= 1'b1;
               busy_q <= 1'b1;
            end else begin
               deny <= 1'b1;
            end
         end
      end
   end

   assign status = {lock_q, 2'b00, bp_q, wel_q, busy_q};
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       ev_wrsr,
   input logic       ev_prog,
   input logic       ev_sect_erase,
   input logic       ev_blk32_erase,
   input logic       ev_blk64_erase,
   input logic       ev_chip_erase,
   input logic       wp_n,
   input logic [7:0] status,
   input logic       grant,
   input logic       deny
);
   logic any_req;
   assign any_req = ev_wrsr || ev_prog || ev_sect_erase || ev_blk32_erase
                    || ev_blk64_erase || ev_chip_erase;

   // R4
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status[6:5] == 2'b00);

   // R3
   wel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> $past(status[1]));

   // R9
   grant_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> status[0]);

   // R10
   busy_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status[0] && any_req) |=> (deny && !grant));

   // R5
   hw_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!status[0] && ev_wrsr && status[7] && !wp_n) |=> deny);

   // R8
   chip_bp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_chip_erase && status[4:2] != 3'b000) |=> !grant);

   // R11
   deny_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (deny && !$past(status[0])) |-> (status[1] == $past(status[1])));

   // R12
   one_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(grant && deny));
endmodule

bind flash_status_guard fsg_checker i_fsg_checker (
   .clk            (clk),
   .rst_n          (rst_n),
   .ev_wrsr        (ev_wrsr),
   .ev_prog        (ev_prog),
   .ev_sect_erase  (ev_sect_erase),
   .ev_blk32_erase (ev_blk32_erase),
   .ev_blk64_erase (ev_blk64_erase),
   .ev_chip_erase  (ev_chip_erase),
   .wp_n           (wp_n),
   .status         (status),
   .grant          (grant),
   .deny           (deny)
);

// File: tb/test_flash_status_guard.sv
module test_flash_status_guard;
   localparam int NCYC = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ev_wren = 0, ev_wrdi = 0, ev_wrsr = 0, ev_prog = 0, ev_sect = 0;
   logic ev_b32 = 0, ev_b64 = 0, ev_chip = 0, wp_n = 1, cyc_done = 0;
   logic [7:0]  wdata = 8'h00;
   logic [23:0] addr = '0;
   logic [7:0]  status;
   logic        grant, deny;

   int checks = 0, fails = 0;
   string tag = "R1";

   always #4 clk = ~clk;

   flash_status_guard #(.ADDR_W(24), .ARRAY_AW(16), .WRSR_CYCLES(NCYC)) i_flash_status_guard (
      .clk(clk), .rst_n(rst_n), .ev_wren(ev_wren), .ev_wrdi(ev_wrdi),
      .ev_wrsr(ev_wrsr), .wrsr_data(wdata), .ev_prog(ev_prog),
      .ev_sect_erase(ev_sect), .ev_blk32_erase(ev_b32),
      .ev_blk64_erase(ev_b64), .ev_chip_erase(ev_chip), .req_addr(addr),
      .wp_n(wp_n), .cycle_done(cyc_done), .status(status),
      .grant(grant), .deny(deny));

   // behavioural reference model
   int m_lock, m_bp, m_wel, m_busy, m_wrsr, m_rem, m_pend, m_grant, m_deny;

   function automatic int lim_of(int bp);
      case (bp)
         0: return 0;
         1: return 57344;
         2: return 49152;
         3: return 32768;
         default: return 65536;
      endcase
   endfunction

   function automatic int base_of(int a, int sz);
      return (a % 65536) / sz * sz;
   endfunction

   always @(posedge clk) begin
      int ok, b;
      if (!rst_n) begin
         m_lock = 0; m_bp = 0; m_wel = 0; m_busy = 0; m_wrsr = 0;
         m_rem = 0; m_pend = 0; m_grant = 0; m_deny = 0;
      end else begin
         m_grant = 0; m_deny = 0;
         if (m_busy == 1) begin
            if (ev_wrsr || ev_prog || ev_sect || ev_b32 || ev_b64 || ev_chip) m_deny = 1;
            if (m_wrsr == 1) begin
               if (m_rem == 1) begin
                  m_lock = (m_pend / 128) % 2; m_bp = (m_pend / 4) % 8;
                  m_wel = 0; m_busy = 0; m_wrsr = 0;
               end else m_rem = m_rem - 1;
            end else if (cyc_done) begin
               m_wel = 0; m_busy = 0;
            end
         end else if (ev_wren) m_wel = 1;
         else if (ev_wrdi) m_wel = 0;
         else if (ev_wrsr) begin
            if (m_wel == 1 && !(m_lock == 1 && !wp_n)) begin
               m_grant = 1; m_busy = 1; m_wrsr = 1; m_rem = NCYC; m_pend = wdata;
            end else m_deny = 1;
         end else if (ev_prog || ev_sect || ev_b32 || ev_b64 || ev_chip) begin
            if (ev_chip) ok = (m_bp == 0);
            else begin
               if (ev_prog)      b = base_of(addr, 1);
               else if (ev_sect) b = base_of(addr, 4096);
               else if (ev_b32)  b = base_of(addr, 32768);
               else              b = base_of(addr, 65536);
               ok = (b >= lim_of(m_bp));
            end
            if (m_wel == 1 && ok) begin m_grant = 1; m_busy = 1; m_wrsr = 0; end
            else m_deny = 1;
         end
      end
   end

   function automatic int exp_status();
      return m_lock * 128 + m_bp * 4 + m_wel * 2 + m_busy;
   endfunction

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (status != 8'(exp_status()) || grant != 1'(m_grant) || deny != 1'(m_deny)) begin
            fails++;
            $display("FAIL %s model: status=%h grant=%0d deny=%0d expected status=%h grant=%0d deny=%0d",
                     tag, status, grant, deny, exp_status(), m_grant, m_deny);
         end
      end
   end

   task automatic chk(input string t, input logic [9:0] act, input logic [9:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", t, act, exp);
      end
   endtask

   // kind: 0 wren,1 wrdi,2 wrsr,3 prog,4 sect,5 b32,6 b64,7 chip,8 done
   task automatic ev(input int kind, input int a = 0, input int d = 0);
      @(posedge clk); #2;
      addr = 24'(a); wdata = 8'(d);
      case (kind)
         0: ev_wren = 1; 1: ev_wrdi = 1; 2: ev_wrsr = 1; 3: ev_prog = 1;
         4: ev_sect = 1; 5: ev_b32 = 1; 6: ev_b64 = 1; 7: ev_chip = 1;
         default: cyc_done = 1;
      endcase
      @(posedge clk); #2;
      {ev_wren, ev_wrdi, ev_wrsr, ev_prog, ev_sect, ev_b32, ev_b64, ev_chip, cyc_done} = '0;
      @(negedge clk);
   endtask

   // result word: {grant, deny, status}
   function automatic logic [9:0] res();
      return {grant, deny, status};
   endfunction

   task automatic wait_idle();
      for (int i = 0; i < 20 && status[0]; i++) @(negedge clk);
   endtask

   initial begin : stim
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      @(negedge clk);
      tag = "R1"; chk("R1 reset state", res(), 10'h000);

      tag = "R3"; ev(3, 24'h00F000); chk("R3 program without enable", res(), {2'b01, 8'h00});
      tag = "R2"; ev(0); chk("R2 enable sets latch", res(), {2'b00, 8'h02});
      ev(1); chk("R2 disable clears latch", res(), {2'b00, 8'h00});

      tag = "R4"; ev(0); ev(2, 0, 8'hFF);
      chk("R4 write-status accepted, busy", res(), {2'b10, 8'h03});
      tag = "R10"; ev(0); chk("R10 enable ignored while busy", res(), {2'b00, 8'h03});
      ev(3, 24'h00F000); chk("R10 program denied while busy", res(), {2'b01, 8'h03});
      tag = "R4"; @(negedge clk); @(negedge clk);
      chk("R4 busy held for the full count", res(), {2'b00, 8'h9C});
      wait_idle();

      tag = "R5"; wp_n = 0; ev(0); ev(2, 0, 8'h00);
      chk("R5 locked write-status denied", res(), {2'b01, 8'h9E});
      tag = "R11"; chk("R11 latch kept after deny", {2'b00, status}, {2'b00, 8'h9E});
      tag = "R4"; wp_n = 1; ev(2, 0, 8'h67); wait_idle();
      chk("R4 reserved and low data bits dropped", res(), {2'b00, 8'h04});

      tag = "R7"; ev(0); ev(3, 24'h00DFFF);
      chk("R7 program inside BP=001 range", res(), {2'b01, 8'h06});
      tag = "R9"; ev(3, 24'h00E000);
      chk("R9 program above range granted", res(), {2'b10, 8'h07});
      ev(8); chk("R9 done clears busy and latch", res(), {2'b00, 8'h04});

      tag = "R7"; ev(0); ev(6, 24'h00F000); chk("R7 64K block overlaps", res(), {2'b01, 8'h06});
      ev(5, 24'h00F000); chk("R7 32K block overlaps", res(), {2'b01, 8'h06});
      ev(4, 24'h00E123); chk("R7 sector above range granted", res(), {2'b10, 8'h07});
      ev(8);

      tag = "R8"; ev(0); ev(7); chk("R8 chip erase with BP set", res(), {2'b01, 8'h06});
      ev(2, 0, 8'h00); wait_idle();
      ev(0); ev(7); chk("R8 chip erase with BP clear", res(), {2'b10, 8'h03});
      ev(8);

      tag = "R6"; ev(0); ev(2, 0, 8'h0C); wait_idle();
      ev(0); ev(5, 24'h008000); chk("R6 BP=011 block at 8000h granted", res(), {2'b10, 8'h0F});
      ev(8); ev(0); ev(4, 24'h007FFF); chk("R6 BP=011 sector below denied", res(), {2'b01, 8'h0E});
      ev(2, 0, 8'h10); wait_idle();
      ev(0); ev(3, 24'h00FFFF); chk("R6 BP=1xx protects all", res(), {2'b01, 8'h12});
      tag = "R12"; ev(3, 24'h00FFFF); chk("R12 single answer", {grant ^ deny, 9'h0}, {1'b1, 9'h0});

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule